// File: doc/BRIEF.md
# Sequential Mantissa Multiplier with Window Packing

This block forms the full 128-bit unsigned product of two 64-bit mantissas and then packs a 64-bit window of that product into a mantissa, an 8-bit guard byte and a sticky flag. It is one stage of an extended-precision floating-point datapath. Exponents, rounding and leading-one detection are handled elsewhere.

Only one 32x32 multiplier is instantiated. A start pulse captures both operands and a 2-bit window selector. The block then issues one partial product per cycle: the high-by-high and low-by-low products first, each written straight into its half of the product register, and then the two cross terms, each accumulated into the middle 96 bits. The window selector chooses how many leading product bits are dropped before packing: 0, 1, 31 or 32. Every bit below the guard byte collapses into the sticky flag, which is also folded into bit 0 of the guard byte.

A one-cycle done pulse marks the cycle in which the packed result is valid. The raw 128-bit product stays visible on its own port for checking.

Top module: `mant_mul_pack`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, busy_o and done_o are 0 and prod_o is all zeros.
- R2: A start_i sampled high while busy_o is low is accepted. busy_o is then high for the next five cycles. done_o is high only in the fifth of those cycles, and for exactly one cycle. busy_o returns low in the cycle after done_o.
- R3: When done_o is high, prod_o equals the full unsigned 128-bit product of the accepted operands. prod_o holds that value until the next start is accepted.
- R4: Carries from both cross-term additions reach the top 32 product bits. For two all-ones operands, prod_o = 0xFFFFFFFFFFFFFFFE0000000000000001.
- R5: Window code 2'b00 drops no leading bits: mant_o = prod[127:64], the raw guard byte = prod[63:56], and sticky_o = OR of prod[55:0].
- R6: Window code 2'b01 drops 1 bit: mant_o = prod[126:63], the raw guard byte = prod[62:55], and sticky_o = OR of prod[54:0].
- R7: Window code 2'b10 drops 31 bits: mant_o = prod[96:33], the raw guard byte = prod[32:25], and sticky_o = OR of prod[24:0].
- R8: Window code 2'b11 drops 32 bits: mant_o = prod[95:32], the raw guard byte = prod[31:24], and sticky_o = OR of prod[23:0].
- R9: guard_o[7:1] equals the raw guard byte bits [7:1], and guard_o[0] = raw guard bit 0 OR sticky_o. The window code in force is the one captured at the accepted start.
- R10: A start_i that arrives while busy_o is high, including the done cycle, is ignored. It produces no extra done pulse, and the result reflects the operands of the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; captures operands and window |
| a_i | input | 64 | Multiplicand mantissa |
| b_i | input | 64 | Multiplier mantissa |
| win_i | input | 2 | Window code: 00=drop 0, 01=drop 1, 10=drop 31, 11=drop 32 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse; packed result valid |
| prod_o | output | 128 | Full product register |
| mant_o | output | 64 | Packed mantissa |
| guard_o | output | 8 | Guard byte with sticky folded into bit 0 |
| sticky_o | output | 1 | OR of all product bits below the guard byte |

## Verification
The done pulse and a new start request can fall in the same cycle. In that cycle the block is still busy, so the request must be dropped. The bench provokes this by holding start_i high, with different operands, from the cycle after an accepted start through the done cycle. It then releases start_i and checks three things: exactly one done pulse appears, the result still matches the first operands, and busy_o falls on the following cycle. A start driven in the first idle cycle after done is also exercised, to show that back-to-back acceptance is not blocked.

// File: rtl/mmp_pkg.sv
package mmp_pkg;
  localparam int unsigned MANT_W  = 64;
  localparam int unsigned GUARD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HH     = 3'd1,
    ST_LL     = 3'd2,
    ST_CROSS1 = 3'd3,
    ST_CROSS2 = 3'd4,
    ST_PACK   = 3'd5
  } mmp_state_e;

  typedef enum logic [1:0] {
    WIN_DROP0  = 2'b00,
    WIN_DROP1  = 2'b01,
    WIN_DROPHM = 2'b10,
    WIN_DROPH  = 2'b11
  } mmp_win_e;

  // leading bits dropped for window index, given half-mantissa width
  function automatic int unsigned win_drop(input int unsigned idx, input int unsigned half_w);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return half_w - 1;
      default: return half_w;
    endcase
  endfunction
endpackage

// File: rtl/mmp_ctrl.sv
module mmp_ctrl
  import mmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output mmp_state_e state_o,
  output logic       load_o,
  output logic       busy_o,
  output logic       done_o
);
  mmp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_HH;
      ST_HH:     state_d = ST_LL;
      ST_LL:     state_d = ST_CROSS1;
      ST_CROSS1: state_d = ST_CROSS2;
      ST_CROSS2: state_d = ST_PACK;
      ST_PACK:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_PACK);
endmodule

// File: rtl/mmp_mul.sv
module mmp_mul #(
  parameter int unsigned HALF_W = 32
) (
  input  logic [HALF_W-1:0]   x_i,
  input  logic [HALF_W-1:0]   y_i,
  output logic [2*HALF_W-1:0] p_o
);
  localparam int unsigned PW = 2 * HALF_W;
  assign p_o = PW'(x_i) * PW'(y_i);
endmodule

// File: rtl/mmp_datapath.sv
module mmp_datapath
  import mmp_pkg::*;
#(
  parameter int unsigned MW = MANT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  mmp_state_e      state_i,
  input  logic [MW-1:0]   a_i,
  input  logic [MW-1:0]   b_i,
  output logic [2*MW-1:0] prod_o
);
  localparam int unsigned HW = MW / 2;
  localparam int unsigned PW = 2 * MW;
  localparam int unsigned XW = 3 * HW;  // cross-term accumulation span

  logic [MW-1:0] a_q, b_q;
  logic [HW-1:0] x, y;
  logic [MW-1:0] pp;
  logic [PW-1:0] prod_q;
  logic [XW-1:0] cross_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  always_comb begin
    x = a_q[HW-1:0];
    y = b_q[HW-1:0];
    unique case (state_i)
      ST_HH:     begin x = a_q[MW-1:HW]; y = b_q[MW-1:HW]; end
      ST_CROSS1: begin x = a_q[MW-1:HW]; y = b_q[HW-1:0];  end
      ST_CROSS2: begin x = a_q[HW-1:0];  y = b_q[MW-1:HW]; end
      default:   ;
    endcase
  end

  mmp_mul #(.HALF_W(HW)) i_mul (
    .x_i (x),
    .y_i (y),
    .p_o (pp)
  );

  assign cross_sum = prod_q[PW-1:HW] + XW'(pp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
    end else begin
      unique case (state_i)
        ST_HH:     prod_q[PW-1:MW] <= pp;
        ST_LL:     prod_q[MW-1:0]  <= pp;
        ST_CROSS1,
        ST_CROSS2: prod_q[PW-1:HW] <= cross_sum;
        default:   ;
      endcase
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/mmp_pack.sv
module mmp_pack
  import mmp_pkg::*;
#(
  parameter int unsigned MW = MANT_W,
  parameter int unsigned GW = GUARD_W
) (
  input  logic [2*MW-1:0] prod_i,
  input  mmp_win_e        win_i,
  output logic [MW-1:0]   mant_o,
  output logic [GW-1:0]   guard_o,
  output logic            sticky_o
);
  localparam int unsigned HW   = MW / 2;
  localparam int unsigned PW   = 2 * MW;
  localparam int unsigned NWIN = 4;
  localparam int unsigned SW   = PW - MW - GW;  // sticky span

  logic [MW-1:0] c_mant   [NWIN];
  logic [GW-1:0] c_guard  [NWIN];
  logic          c_sticky [NWIN];

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int unsigned DROP = win_drop(i, HW);
    logic [PW-1:0] sh;
    assign sh          = prod_i << DROP;
    assign c_mant[i]   = sh[PW-1 -: MW];
    assign c_guard[i]  = sh[PW-MW-1 -: GW];
    assign c_sticky[i] = |sh[SW-1:0];
  end

  logic [GW-1:0] raw_guard;
  assign mant_o    = c_mant[win_i];
  assign raw_guard = c_guard[win_i];
  assign sticky_o  = c_sticky[win_i];
  assign guard_o   = {raw_guard[GW-1:1], raw_guard[0] | sticky_o};
endmodule

// File: rtl/mant_mul_pack.sv
module mant_mul_pack
  import mmp_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [63:0]  a_i,
  input  logic [63:0]  b_i,
  input  logic [1:0]   win_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [127:0] prod_o,
  output logic [63:0]  mant_o,
  output logic [7:0]   guard_o,
  output logic         sticky_o
);
  mmp_state_e state;
  logic       load;
  mmp_win_e   win_q;

  mmp_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   win_q <= WIN_DROP0;
    else if (load) win_q <= mmp_win_e'(win_i);
  end

  mmp_datapath #(.MW(MANT_W)) i_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .state_i (state),
    .a_i     (a_i),
    .b_i     (b_i),
    .prod_o  (prod_o)
  );

  mmp_pack #(.MW(MANT_W), .GW(GUARD_W)) i_pack (
    .prod_i   (prod_o),
    .win_i    (win_q),
    .mant_o   (mant_o),
    .guard_o  (guard_o),
    .sticky_o (sticky_o)
  );
endmodule

// File: rtl/mmp_chk.sv
module mmp_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [127:0] prod_o,
  input logic [7:0]   guard_o,
  input logic         sticky_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R2
  AST_START_TAKES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);  // R2
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o, 4) && busy_o));  // R2
  AST_PROD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(prod_o));  // R3
  AST_STICKY_IN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_o |-> guard_o[0]);  // R9
  AST_DONE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);  // R10
endmodule

bind mant_mul_pack mmp_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .prod_o   (prod_o),
  .guard_o  (guard_o),
  .sticky_o (sticky_o)
);

// File: tb/test_mant_mul_pack.sv
`timescale 1ns/1ps
module test_mant_mul_pack;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  a = '0, b = '0;
  logic [1:0]   win = '0;
  logic         busy, done, sticky;
  logic [127:0] prod;
  logic [63:0]  mant;
  logic [7:0]   guard;

  int n_chk = 0;
  int n_bad = 0;
  int n_done = 0;

  always #4 clk = ~clk;  // 125 MHz

  mant_mul_pack i_mant_mul_pack (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .a_i (a), .b_i (b), .win_i (win),
    .busy_o (busy), .done_o (done), .prod_o (prod), .mant_o (mant), .guard_o (guard),
    .sticky_o (sticky)
  );

  // reference model: cycles remaining, captured operands
  int           m_cnt = 0;
  logic [63:0]  m_a = '0, m_b = '0;
  logic [1:0]   m_win = '0;
  logic [127:0] m_last = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_last = '0;
    end else if (m_cnt == 0) begin
      if (start) begin
        m_cnt = 5; m_a = a; m_b = b; m_win = win;
      end
    end else begin
      if (m_cnt == 1) m_last = {64'd0, m_a} * {64'd0, m_b};
      m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [127:0] p;
      logic [63:0]  em;
      logic [7:0]   eg;
      logic         es;
      string        wt;
      chk(busy === (m_cnt != 0), "R2 busy", 128'(busy), 128'(m_cnt != 0));
      chk(done === (m_cnt == 1), "R2/R10 done", 128'(done), 128'(m_cnt == 1));
      if (done) n_done++;
      if (m_cnt == 1) begin
        p = {64'd0, m_a} * {64'd0, m_b};
        chk(prod === p, "R3 product", prod, p);
        case (m_win)
          2'b00: begin em = p[127:64]; eg = p[63:56]; es = |p[55:0]; wt = "R5"; end
          2'b01: begin em = p[126:63]; eg = p[62:55]; es = |p[54:0]; wt = "R6"; end
          2'b10: begin em = p[96:33];  eg = p[32:25]; es = |p[24:0]; wt = "R7"; end
          default: begin em = p[95:32]; eg = p[31:24]; es = |p[23:0]; wt = "R8"; end
        endcase
        eg[0] = eg[0] | es;
        chk(mant === em, {wt, " mant"}, 128'(mant), 128'(em));
        chk(sticky === es, {wt, " R9 sticky"}, 128'(sticky), 128'(es));
        chk(guard === eg, {wt, " R9 guard"}, 128'(guard), 128'(eg));
      end else if (m_cnt == 0) begin
        chk(prod === m_last, "R3 hold", prod, m_last);
      end
    end
  end

  // start at a negedge, return at the first idle negedge after done
  task automatic run(input logic [63:0] x, input logic [63:0] y, input logic [1:0] w);
    a = x; b = y; win = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", 128'({busy, done}), 128'(0));
    chk(prod === '0, "R1 prod in reset", prod, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(prod === '0 && !busy && !done, "R1 after release", prod, '0);

    // R4: carries from both cross terms into top bits
    run('1, '1, 2'b00);
    chk(prod === 128'hFFFFFFFFFFFFFFFE0000000000000001, "R4 all ones", prod,
        128'hFFFFFFFFFFFFFFFE0000000000000001);
    // clean power of two: sticky clear in every window
    for (int w = 0; w < 4; w++) run(64'h8000000000000000, 64'h8000000000000000, 2'(w));
    // low-only product bits to set sticky
    for (int w = 0; w < 4; w++) run(64'h8000000000000001, 64'h0000000000000003, 2'(w));
    run(64'd0, 64'hDEADBEEFCAFEF00D, 2'b11);
    run(64'hFFFFFFFF00000000, 64'h00000000FFFFFFFF, 2'b10);
    for (int k = 0; k < 24; k++)
      run({$urandom, $urandom}, {$urandom, $urandom}, 2'(k));

    // R10: start held through busy and done cycle with other operands
    n_done = 0;
    a = 64'hC000000000000005; b = 64'hA000000000000007; win = 2'b01; start = 1'b1;
    @(negedge clk);
    a = 64'h1111111111111111; b = 64'h2222222222222222; win = 2'b11;
    repeat (5) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(n_done == 1, "R10 single done", 128'(n_done), 128'(1));
    chk(prod === 128'({64'd0, 64'hC000000000000005} * {64'd0, 64'hA000000000000007}),
        "R10 first operands kept", prod,
        128'({64'd0, 64'hC000000000000005} * {64'd0, 64'hA000000000000007}));

    // back-to-back: start in first idle cycle after done
    run(64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 2'b00);
    run(64'h7FFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 2'b01);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule